// File: doc/BRIEF.md
# Terminal Character Port with Handshake Flags

This block sits between a slow serial terminal and a processor accumulator. A keyboard shifts characters in one bit at a time. Once eight bits have arrived, a ready flag rises and the character is held for the processor. A printer receives characters that the processor writes in parallel, and they are sent out one bit per shift pulse.

Each direction has a single 8-bit holding register guarded by one flag. The register is locked while its flag says it holds data the other side has not yet consumed. The fast processor and the slow device are kept in step this way without any queue. The serial side is a plain 8-bit shift, least significant bit first, clocked by an externally supplied shift-enable. Framing and bit-rate timing belong to the surrounding logic.

Top module: `term_io_port`

## Requirements
- R1: After reset `key_full` is 0, `rd_data` is 0, `prn_empty` is 1 and `prn_bit` is 1.
- R2: A `kb_start` pulse arms capture. Each later `kb_shift` pulse inserts `kb_bit` at bit 7 and moves the register right, so the first bit sent ends at bit 0. `key_full` rises at the same clock edge that takes the eighth bit. When `kb_start` and `kb_shift` are high together, `kb_start` wins and the bit is dropped.
- R3: While `key_full` is 1, `kb_start` and `kb_shift` have no effect, and `rd_data` keeps the captured character.
- R4: An `acc_rd` strobe while `key_full` is 1 clears `key_full` at the next edge without altering `rd_data`. A new character may then be captured.
- R5: A `kb_shift` with no prior `kb_start` changes nothing. A `kb_start` during a capture restarts the bit count, so the character is made of the eight bits that follow the latest start.
- R6: An `acc_wr` strobe while `prn_empty` is 1 loads `wr_data` and clears `prn_empty` at the next edge. `prn_bit` then shows bit 0 of the character.
- R7: Each `prn_shift` pulse while a character is pending moves `prn_bit` to the next higher bit. The eighth pulse sets `prn_empty` back to 1, and `prn_bit` then idles at 1.
- R8: An `acc_wr` while `prn_empty` is 0 is ignored: the bits still to be sent and the flag are unchanged.
- R9: An `acc_rd` while `key_full` is 0, and a `prn_shift` while `prn_empty` is 1, have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kb_start | input | 1 | Arms or restarts capture of a keyboard character |
| kb_shift | input | 1 | Keyboard shift-enable, one bit per pulse |
| kb_bit | input | 1 | Keyboard serial data |
| key_full | output | 1 | Input flag: a captured character awaits the processor |
| acc_rd | input | 1 | Processor read strobe, clears `key_full` |
| rd_data | output | 8 | Captured character toward the accumulator |
| acc_wr | input | 1 | Processor write strobe |
| wr_data | input | 8 | Character from the accumulator |
| prn_empty | output | 1 | Output flag: printer register may be written |
| prn_shift | input | 1 | Printer shift-enable, one bit per pulse |
| prn_bit | output | 1 | Printer serial data, 1 when idle |

## Verification
The bench sends keyboard bits while the flag is up and checks that the held character survives. A design that leaked the lock would corrupt `rd_data` before the processor reads it. It also writes to the printer register in the middle of a character. A design without the lock would restart output or change the bits still to go. Restarting a capture after three bits checks that the flag waits for a full eight bits after the latest start, so a miscounting design would raise it early. The all-ones and all-zeros characters, the single-bit characters and the idle level show whether bits come out in the wrong order or the line idles low.

// File: rtl/term_io_pkg.sv
package term_io_pkg;

    typedef enum logic [1:0] {
        KB_IDLE = 2'd0,
        KB_RECV = 2'd1,
        KB_FULL = 2'd2
    } kb_phase_e;

    typedef enum logic {
        PR_EMPTY = 1'b0,
        PR_BUSY  = 1'b1
    } pr_phase_e;

endpackage

// File: rtl/kb_capture.sv
module kb_capture
    import term_io_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              shift_i,
    input  logic              bit_i,
    input  logic              take_i,
    output logic              full_o,
    output logic [DATA_W-1:0] data_o
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        kb_phase_e         phase;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] data;
    } kb_state_t;

    kb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            KB_IDLE: begin
                if (start_i) begin
                    st_d.phase = KB_RECV;
                    st_d.cnt   = '0;
                end
            end
            KB_RECV: begin
                if (start_i) begin
                    st_d.cnt = '0;
                end else if (shift_i) begin
                    st_d.data = {bit_i, st_q.data[DATA_W-1:1]};
                    if (st_q.cnt == LAST) begin
                        st_d.phase = KB_FULL;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            KB_FULL: begin
                if (take_i) begin
                    st_d.phase = KB_IDLE;
                end
            end
            default: st_d.phase = KB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= KB_IDLE;
            st_q.cnt   <= '0;
            st_q.data  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign full_o = (st_q.phase == KB_FULL);
    assign data_o = st_q.data;

    // R2
    kb_full_after_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_o) |-> $past(shift_i));

    // R3
    kb_locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |=> $stable(data_o));

    // R4
    kb_take_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && take_i) |=> !full_o);

    // R9
    kb_take_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_o && take_i && !shift_i) |=> ($stable(data_o) && !full_o));

endmodule

// File: rtl/prn_serializer.sv
module prn_serializer
    import term_io_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_data_i,
    input  logic              shift_i,
    output logic              empty_o,
    output logic              line_o
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        pr_phase_e         phase;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] shreg;
    } pr_state_t;

    pr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PR_EMPTY: begin
                if (load_i) begin
                    st_d.phase = PR_BUSY;
                    st_d.cnt   = '0;
                    st_d.shreg = load_data_i;
                end
            end
            PR_BUSY: begin
                if (shift_i) begin
                    st_d.shreg = {1'b0, st_q.shreg[DATA_W-1:1]};
                    if (st_q.cnt == LAST) begin
                        st_d.phase = PR_EMPTY;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            default: st_d.phase = PR_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= PR_EMPTY;
            st_q.cnt   <= '0;
            st_q.shreg <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign empty_o = (st_q.phase == PR_EMPTY);
    assign line_o  = (st_q.phase == PR_BUSY) ? st_q.shreg[0] : 1'b1;

    // R6
    pr_load_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && load_i) |=> !empty_o);

    // R7
    pr_empty_after_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(empty_o) |-> $past(shift_i));

    // R7
    pr_idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o |-> line_o);

    // R8
    pr_busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_o && !shift_i) |=> ($stable(line_o) && !empty_o));

endmodule

// File: rtl/term_io_port.sv
module term_io_port #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kb_start,
    input  logic              kb_shift,
    input  logic              kb_bit,
    output logic              key_full,
    input  logic              acc_rd,
    output logic [DATA_W-1:0] rd_data,
    input  logic              acc_wr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              prn_empty,
    input  logic              prn_shift,
    output logic              prn_bit
);

    kb_capture #(.DATA_W(DATA_W)) u_kb (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (kb_start),
        .shift_i (kb_shift),
        .bit_i   (kb_bit),
        .take_i  (acc_rd),
        .full_o  (key_full),
        .data_o  (rd_data)
    );

    prn_serializer #(.DATA_W(DATA_W)) u_prn (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (acc_wr),
        .load_data_i (wr_data),
        .shift_i     (prn_shift),
        .empty_o     (prn_empty),
        .line_o      (prn_bit)
    );

endmodule

// File: tb/term_io_port_test.sv
module term_io_port_test;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NCHAR = 6;
    localparam logic [7:0] CHARS [NCHAR] = '{8'h41, 8'h00, 8'hFF, 8'h5A, 8'h80, 8'h01};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       kb_start = 1'b0, kb_shift = 1'b0, kb_bit = 1'b0;
    logic       acc_rd = 1'b0, acc_wr = 1'b0, prn_shift = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       key_full, prn_empty, prn_bit;
    logic [7:0] rd_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    term_io_port #(.DATA_W(8)) uut (
        .clk(clk), .rst_n(rst_n),
        .kb_start(kb_start), .kb_shift(kb_shift), .kb_bit(kb_bit),
        .key_full(key_full), .acc_rd(acc_rd), .rd_data(rd_data),
        .acc_wr(acc_wr), .wr_data(wr_data),
        .prn_empty(prn_empty), .prn_shift(prn_shift), .prn_bit(prn_bit)
    );

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        kb_start = 0; kb_shift = 0; acc_rd = 0; acc_wr = 0; prn_shift = 0;
    endtask

    task automatic kb_go();
        @(negedge clk); kb_start = 1; kb_shift = 0;
        idle();
    endtask

    task automatic kb_send_bits(input logic [7:0] c, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk); kb_shift = 1; kb_bit = c[i];
        end
        idle();
    endtask

    task automatic rd_pulse();
        @(negedge clk); acc_rd = 1;
        idle();
    endtask

    task automatic wr_pulse(input logic [7:0] c);
        @(negedge clk); acc_wr = 1; wr_data = c;
        idle();
    endtask

    task automatic prn_pulse();
        @(negedge clk); prn_shift = 1;
        idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual %h expected %h", 8'h00, 8'h01);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(key_full == 0, "R1 key_full", {7'b0, key_full}, 8'h00);
        check(rd_data == 0, "R1 rd_data", rd_data, 8'h00);
        check(prn_empty == 1, "R1 prn_empty", {7'b0, prn_empty}, 8'h01);
        check(prn_bit == 1, "R1 prn_bit", {7'b0, prn_bit}, 8'h01);

        // vector walk: R2 R4 R6 R7
        for (int v = 0; v < NCHAR; v++) begin
            logic [7:0] c;
            c = CHARS[v];
            kb_go();
            kb_send_bits(c, 7);
            check(key_full == 0, "R2 flag low before 8th bit", {7'b0, key_full}, 8'h00);
            kb_send_bits({1'b0, c[7:1]} >> 6, 1);
            check(key_full == 1, "R2 flag after 8 bits", {7'b0, key_full}, 8'h01);
            check(rd_data == c, "R2 captured char", rd_data, c);
            rd_pulse();
            check(key_full == 0, "R4 read clears flag", {7'b0, key_full}, 8'h00);
            check(rd_data == c, "R4 data kept after read", rd_data, c);
            wr_pulse(c);
            check(prn_empty == 0, "R6 write clears empty", {7'b0, prn_empty}, 8'h00);
            for (int i = 0; i < 8; i++) begin
                check(prn_bit == c[i], "R7 serial bit", {7'b0, prn_bit}, {7'b0, c[i]});
                prn_pulse();
            end
            check(prn_empty == 1, "R7 empty after 8 shifts", {7'b0, prn_empty}, 8'h01);
            check(prn_bit == 1, "R7 idle level", {7'b0, prn_bit}, 8'h01);
        end

        // R3: lock while full
        kb_go();
        kb_send_bits(8'hC3, 8);
        kb_go();
        kb_send_bits(8'h3C, 8);
        check(rd_data == 8'hC3, "R3 data locked", rd_data, 8'hC3);
        check(key_full == 1, "R3 flag held", {7'b0, key_full}, 8'h01);
        rd_pulse();
        // R4: new character accepted after read
        kb_go();
        kb_send_bits(8'h96, 8);
        check(rd_data == 8'h96, "R4 next char accepted", rd_data, 8'h96);
        rd_pulse();

        // R5: shift without start ignored
        kb_send_bits(8'hFF, 8);
        check(rd_data == 8'h96, "R5 unarmed shift ignored", rd_data, 8'h96);
        check(key_full == 0, "R5 unarmed flag low", {7'b0, key_full}, 8'h00);
        // R5: restart mid-character
        kb_go();
        kb_send_bits(8'h07, 3);
        kb_go();
        kb_send_bits(8'hA5, 5);
        check(key_full == 0, "R5 restart count", {7'b0, key_full}, 8'h00);
        kb_send_bits(8'h05, 3);
        check(key_full == 1, "R5 full after restart", {7'b0, key_full}, 8'h01);
        check(rd_data == 8'hA5, "R5 restarted char", rd_data, 8'hA5);
        rd_pulse();

        // R9: read while empty, shift while printer empty
        rd_pulse();
        check(rd_data == 8'hA5, "R9 empty read data", rd_data, 8'hA5);
        check(key_full == 0, "R9 empty read flag", {7'b0, key_full}, 8'h00);
        prn_pulse();
        check(prn_empty == 1, "R9 idle shift empty", {7'b0, prn_empty}, 8'h01);
        check(prn_bit == 1, "R9 idle shift line", {7'b0, prn_bit}, 8'h01);

        // R8: write while busy ignored
        wr_pulse(8'b1011_0010);
        prn_pulse();
        prn_pulse();
        wr_pulse(8'h4D);
        check(prn_empty == 0, "R8 still busy", {7'b0, prn_empty}, 8'h00);
        for (int i = 2; i < 8; i++) begin
            check(prn_bit == (8'b1011_0010 >> i) % 2, "R8 remaining bit", {7'b0, prn_bit},
                  {7'b0, 1'((8'b1011_0010 >> i) % 2)});
            prn_pulse();
        end
        check(prn_empty == 1, "R8 finished original", {7'b0, prn_empty}, 8'h01);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule